// File: doc/BRIEF.md
# MDIO Management Controller

This block is a register-mapped controller for the two-wire PHY management bus. Software programs a PHY address and a register number, then either writes a data word, which sends a write frame, or raises a read command bit, which sends a read frame. The block generates the management clock from the system clock through a programmable power-of-two divider. It serialises every frame bit, releases the data line while the PHY answers, and collects the 16 returned bits into a status register. Software polls the indication register until the busy and not-valid flags clear.

Each frame is 64 management-clock periods long. It carries 32 ones as preamble, then a start pair `01`, an opcode (`01` write, `10` read), five PHY address bits, five register bits, a two-bit turnaround and sixteen data bits. All fields are sent most significant bit first. A soft reset written through the configuration register aborts any frame in progress.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The registers sit at word offsets 0 configuration, 1 command, 2 address, 3 control, 4 status and 5 indication. Offsets 6 and 7 read 0. The divider reads back in configuration bits 2:0 and the read command in command bit 0. The address register holds the PHY address in bits 12:8 and the register number in bits 4:0. The control register reads back its low 16 bits.
- R2: A control-register write while idle starts a write frame. The frame's bit k is bit 63-k of {32 ones, 01, 01, phy[4:0], reg[4:0], 10, data[15:0]}, and the data line is driven for all 64 bits.
- R3: A read frame starts only when a command write moves bit 0 from 0 to 1 while idle. Writing 1 while the bit is already 1 starts nothing.
- R4: Indication bit 0 (busy) goes high in the cycle after the starting write. It stays high for exactly 128·H system clocks and then drops.
- R5: Indication bit 2 (not-valid) is high from the start of a read until the cycle in which the status register (bits 15:0) holds the 16 bits returned by that read.
- R6: The management clock is low when idle and starts low at a frame start. Its half-period is H = 2^(divider+1) system clocks. The data output changes only in the cycle after a falling clock edge.
- R7: On a read, output enable is high for bits 0 to 45 and low for turnaround and data (bits 46 to 63). Data bits are sampled at the 16 rising clock edges of bits 48 to 63, first bit into bit 15.
- R8: Command and control writes that arrive while busy change neither the register nor the frame in progress.
- R9: A configuration write with bit 31 set aborts any frame and clears busy, not-valid and the command bit, all in the next cycle. It loads the divider from bits 2:0. Bit 31 reads 1 for that one cycle and 0 afterwards.
- R10: After reset the configuration reads 7 (slowest clock), and every other register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_ofs | input | 3 | Word offset of the write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_ofs | input | 3 | Word offset of the read |
| reg_rd_data | output | 32 | Read data, combinational from the read offset |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
Register contents and flags respond in the system clock cycle after the write. Busy and not-valid rise one cycle after an accepted write, and they fall exactly 128·H cycles later, in the same cycle as the status update. The management clock changes level every H cycles, counted from the first busy cycle, and the data output follows each falling level change by zero extra cycles. A behavioural model keeps a single elapsed-cycle count per frame, derives the expected clock level, bit index and drive state from it, and compares every output and the selected register one time unit after each falling system-clock edge. Inputs are stable at that moment.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_W     = 5;
    localparam int REG_W     = 5;
    localparam int DATA_W    = 16;
    localparam int FRAME_LEN = 64;
    localparam int OFS_W     = 3;
    localparam int IDX_W     = 6;

    localparam logic [IDX_W-1:0] IDX_TA   = 6'd46;
    localparam logic [IDX_W-1:0] IDX_DATA = 6'd48;
    localparam logic [IDX_W-1:0] IDX_LAST = 6'd63;

    localparam logic [OFS_W-1:0] OFS_CFG = 3'd0;
    localparam logic [OFS_W-1:0] OFS_CMD = 3'd1;
    localparam logic [OFS_W-1:0] OFS_ADR = 3'd2;
    localparam logic [OFS_W-1:0] OFS_CTL = 3'd3;
    localparam logic [OFS_W-1:0] OFS_STS = 3'd4;
    localparam logic [OFS_W-1:0] OFS_IND = 3'd5;

    typedef struct packed {
        logic              is_read;
        logic [PHY_W-1:0]  phy;
        logic [REG_W-1:0]  regn;
        logic [DATA_W-1:0] wdata;
    } mdio_req_t;

    function automatic logic [FRAME_LEN-1:0] build_frame(mdio_req_t r);
        logic [1:0]        op;
        logic [DATA_W-1:0] dat;
        op  = r.is_read ? 2'b10 : 2'b01;
        dat = r.is_read ? {DATA_W{1'b1}} : r.wdata;
        return {32'hFFFF_FFFF, 2'b01, op, r.phy, r.regn, 2'b10, dat};
    endfunction

endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [OFS_W-1:0]      wr_ofs,
    input  logic [31:0]           wr_data,
    input  logic [OFS_W-1:0]      rd_ofs,
    output logic [31:0]           rd_data,
    input  logic                  busy,
    input  logic                  nv,
    input  logic [DATA_W-1:0]     status,
    output logic                  start,
    output mdio_req_t             req,
    output logic                  soft_clr,
    output logic [DIV_W-1:0]      div
);

    logic             rstflag_q;
    logic [DIV_W-1:0] div_q;
    logic             cmd_q;
    logic [PHY_W-1:0] phy_q;
    logic [REG_W-1:0] reg_q;
    logic [DATA_W-1:0] ctl_q;
    logic hit_cfg, hit_cmd, hit_adr, hit_ctl;
    logic start_rd, start_wr;
    logic unused_wbits;

    assign unused_wbits = ^wr_data[30:16];

    assign hit_cfg  = wr_en && (wr_ofs == OFS_CFG);
    assign hit_cmd  = wr_en && (wr_ofs == OFS_CMD);
    assign hit_adr  = wr_en && (wr_ofs == OFS_ADR);
    assign hit_ctl  = wr_en && (wr_ofs == OFS_CTL);

    assign soft_clr = hit_cfg && wr_data[31];
    assign start_rd = hit_cmd && !busy && wr_data[0] && !cmd_q;
    assign start_wr = hit_ctl && !busy;
    assign start    = start_rd || start_wr;
    assign div      = div_q;

    always_comb begin
        req.is_read = start_rd;
        req.phy     = phy_q;
        req.regn    = reg_q;
        req.wdata   = wr_data[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rstflag_q <= 1'b0;
            div_q     <= '1;
            cmd_q     <= 1'b0;
            phy_q     <= '0;
            reg_q     <= '0;
            ctl_q     <= '0;
        end else begin
            rstflag_q <= soft_clr;
            if (hit_cfg)
                div_q <= wr_data[DIV_W-1:0];
            if (soft_clr)
                cmd_q <= 1'b0;
            else if (hit_cmd && !busy)
                cmd_q <= wr_data[0];
            if (hit_adr) begin
                phy_q <= wr_data[8 +: PHY_W];
                reg_q <= wr_data[0 +: REG_W];
            end
            if (start_wr)
                ctl_q <= wr_data[DATA_W-1:0];
        end
    end

    always_comb begin
        case (rd_ofs)
            OFS_CFG: rd_data = {rstflag_q, {(31-DIV_W){1'b0}}, div_q};
            OFS_CMD: rd_data = {31'b0, cmd_q};
            OFS_ADR: rd_data = {19'b0, phy_q, 3'b0, reg_q};
            OFS_CTL: rd_data = {16'b0, ctl_q};
            OFS_STS: rd_data = {16'b0, status};
            OFS_IND: rd_data = {29'b0, nv, 1'b0, busy};
            default: rd_data = 32'b0;
        endcase
    end

    // R8: a control write while busy leaves the register alone
    p_ctl_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy && hit_ctl |=> $stable(ctl_q));

    // R8: a command write while busy leaves the command bit alone
    p_cmd_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy && hit_cmd && !soft_clr |=> $stable(cmd_q));

    // R9: the reset indication lasts one cycle
    p_rstflag_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rstflag_q && !soft_clr |=> !rstflag_q);

endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);

    localparam int CNT_W = 1 << DIV_W;

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             mdc_q;
    logic             tick;

    always_comb last = {CNT_W{1'b1}} >> (CNT_W - 1 - int'(div_q));

    assign tick = run && (cnt_q == last);
    assign rise = tick && !mdc_q;
    assign fall = tick && mdc_q;
    assign mdc  = mdc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '1;
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (restart) begin
            div_q <= div_in;
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= !mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: the clock rests low outside a frame
    p_mdc_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !run && !restart |=> !mdc);

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_clr,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_in,
    output logic              busy,
    output logic              nv,
    output logic [DATA_W-1:0] status,
    output logic              mdio_out,
    output logic              mdio_oe
);

    logic [FRAME_LEN-1:0] sh_q;
    logic [IDX_W-1:0]     idx_q;
    logic [IDX_W-1:0]     idx_nxt;
    logic [DATA_W-1:0]    cap_q;
    logic                 rd_q;
    logic                 finish;

    assign idx_nxt = idx_q + 6'd1;
    assign finish  = busy && fall && (idx_q == IDX_LAST);

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            busy     <= 1'b0;
            nv       <= 1'b0;
            mdio_oe  <= 1'b0;
            mdio_out <= 1'b1;
            idx_q    <= '0;
            rd_q     <= 1'b0;
            sh_q     <= '0;
            cap_q    <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            nv       <= req.is_read;
            rd_q     <= req.is_read;
            idx_q    <= '0;
            sh_q     <= build_frame(req);
            mdio_out <= build_frame(req)[FRAME_LEN-1];
            mdio_oe  <= 1'b1;
            cap_q    <= '0;
        end else if (busy && rise) begin
            if (rd_q && idx_q >= IDX_DATA)
                cap_q <= {cap_q[DATA_W-2:0], mdio_in};
        end else if (busy && fall) begin
            if (idx_q == IDX_LAST) begin
                busy     <= 1'b0;
                nv       <= 1'b0;
                mdio_oe  <= 1'b0;
                mdio_out <= 1'b1;
            end else begin
                idx_q    <= idx_nxt;
                sh_q     <= {sh_q[FRAME_LEN-2:0], 1'b0};
                mdio_out <= sh_q[FRAME_LEN-2];
                mdio_oe  <= !(rd_q && idx_nxt >= IDX_TA);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            status <= '0;
        else if (!soft_clr && finish && rd_q)
            status <= cap_q;
    end

    // R5: not-valid is only ever raised inside a frame
    p_nv_in_frame_r5: assert property (@(posedge clk) disable iff (rst)
        nv |-> busy);

    // R6: data output holds except after a falling clock edge
    p_out_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && !$past(fall) && !$past(start) |-> $stable(mdio_out));

    // R7: line released for turnaround and data of a read
    p_release_ta_r7: assert property (@(posedge clk) disable iff (rst)
        busy && rd_q && (idx_q >= IDX_TA) |-> !mdio_oe);

    // R2: a write frame drives every bit
    p_write_drives_r2: assert property (@(posedge clk) disable iff (rst)
        busy && !rd_q |-> mdio_oe);

    // R4: a normal end of frame happens only after the last bit
    p_end_idx_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) && !$past(soft_clr) |-> $past(idx_q) == IDX_LAST);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [2:0]  reg_wr_ofs,
    input  logic [31:0] reg_wr_data,
    input  logic [2:0]  reg_rd_ofs,
    output logic [31:0] reg_rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic              busy, nv, start, soft_clr, rise, fall;
    logic [DATA_W-1:0] status;
    logic [DIV_W-1:0]  div;
    mdio_req_t         req;

    mdio_regs #(.DIV_W(DIV_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_ofs   (reg_wr_ofs),
        .wr_data  (reg_wr_data),
        .rd_ofs   (reg_rd_ofs),
        .rd_data  (reg_rd_data),
        .busy     (busy),
        .nv       (nv),
        .status   (status),
        .start    (start),
        .req      (req),
        .soft_clr (soft_clr),
        .div      (div)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .restart (start || soft_clr),
        .run     (busy),
        .div_in  (div),
        .mdc     (mdc),
        .rise    (rise),
        .fall    (fall)
    );

    mdio_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .soft_clr (soft_clr),
        .start    (start),
        .req      (req),
        .rise     (rise),
        .fall     (fall),
        .mdio_in  (mdio_i),
        .busy     (busy),
        .nv       (nv),
        .status   (status),
        .mdio_out (mdio_o),
        .mdio_oe  (mdio_oe)
    );

endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_ofs = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic [2:0]  rd_ofs = 3'd5;
    logic [31:0] rd_data;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_drv = 1'b1;
    logic [15:0] phy_word = 16'h0000;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign mdio_i = (mdio_oe ? mdio_o : 1'b1) & phy_drv;

    mdio_mgmt_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr_en(wr_en), .reg_wr_ofs(wr_ofs),
        .reg_wr_data(wr_data), .reg_rd_ofs(rd_ofs), .reg_rd_data(rd_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // behavioural model
    logic [2:0]  m_div;
    logic        m_rstf, m_cmd, m_busy, m_nv, m_read, busy_pre;
    logic [4:0]  m_phy, m_reg;
    logic [15:0] m_ctrl, m_status, m_cap;
    logic [63:0] m_vec;
    int          m_t, m_h;

    function automatic int cur_idx();
        return m_t / (2 * m_h);
    endfunction

    task automatic begin_frame(input logic rd, input logic [15:0] d);
        m_busy = 1; m_read = rd; m_nv = rd; m_t = 0; m_cap = 0;
        m_h = 1 << (m_div + 1);
        m_vec = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), m_phy, m_reg, 2'b10,
                 (rd ? 16'hFFFF : d)};
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_div = 3'd7; m_rstf = 0; m_cmd = 0; m_busy = 0; m_nv = 0; m_read = 0;
            m_phy = 0; m_reg = 0; m_ctrl = 0; m_status = 0; m_cap = 0; m_t = 0; m_h = 256;
            m_vec = 0;
        end else begin
            busy_pre = m_busy;
            if (m_busy) begin
                if ((m_t % (2 * m_h)) == m_h - 1 && m_read && cur_idx() >= 48)
                    m_cap = {m_cap[14:0], mdio_i};
                if (m_t == 128 * m_h - 1) begin
                    m_busy = 0; m_nv = 0;
                    if (m_read) m_status = m_cap;
                end else m_t++;
            end
            m_rstf = 0;
            if (wr_en) begin
                case (wr_ofs)
                    3'd0: begin
                        m_div = wr_data[2:0];
                        if (wr_data[31]) begin m_rstf = 1; m_cmd = 0; m_busy = 0; m_nv = 0; end
                    end
                    3'd1: if (!busy_pre) begin
                        if (wr_data[0] && !m_cmd) begin_frame(1, 16'h0);
                        m_cmd = wr_data[0];
                    end
                    3'd2: begin m_phy = wr_data[12:8]; m_reg = wr_data[4:0]; end
                    3'd3: if (!busy_pre) begin
                        m_ctrl = wr_data[15:0];
                        begin_frame(0, wr_data[15:0]);
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_reg(input logic [2:0] o);
        case (o)
            3'd0: return {m_rstf, 28'b0, m_div};
            3'd1: return {31'b0, m_cmd};
            3'd2: return {19'b0, m_phy, 3'b0, m_reg};
            3'd3: return {16'b0, m_ctrl};
            3'd4: return {16'b0, m_status};
            3'd5: return {29'b0, m_nv, 1'b0, m_busy};
            default: return 32'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            logic e_mdc, e_oe;
            int   k;
            k     = m_busy ? cur_idx() : 0;
            e_mdc = m_busy ? (((m_t / m_h) % 2) == 1) : 1'b0;
            e_oe  = m_busy && (!m_read || k < 46);
            chk("R6 mdc level", {31'b0, mdc}, {31'b0, e_mdc});
            chk("R7 output enable", {31'b0, mdio_oe}, {31'b0, e_oe});
            if (e_oe) chk("R2 frame bit", {31'b0, mdio_o}, {31'b0, m_vec[63-k]});
            case (rd_ofs)
                3'd0: chk("R9 cfg read", rd_data, exp_reg(rd_ofs));
                3'd4: chk("R5 status read", rd_data, exp_reg(rd_ofs));
                3'd5: chk("R4 indication read", rd_data, exp_reg(rd_ofs));
                default: chk("R1 register read", rd_data, exp_reg(rd_ofs));
            endcase
            if (m_busy && m_read && k >= 47)
                phy_drv = (k == 47) ? 1'b0 : phy_word[15-(k-48)];
            else
                phy_drv = 1'b1;
        end
    end

    task automatic bus_write(input logic [2:0] o, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_ofs = o; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic read_reg(input logic [2:0] o, output logic [31:0] v);
        @(negedge clk);
        rd_ofs = o;
        #2 v = rd_data;
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL R4 watchdog act=busy exp=idle");
        summary();
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 0;
        // R10 reset state
        read_reg(3'd0, v); chk("R10 cfg reset", v, 32'h7);
        for (int o = 1; o < 8; o++) begin
            read_reg(o[2:0], v); chk("R10 reg reset", v, 32'h0);
        end
        // R1 readback
        bus_write(3'd2, 32'h0000_1F1A);
        read_reg(3'd2, v); chk("R1 address fields", v, 32'h0000_1F1A);
        bus_write(3'd2, 32'hFFFF_E5E3);
        read_reg(3'd2, v); chk("R1 address masked", v, 32'h0000_0503);
        bus_write(3'd0, 32'h0000_0000);
        // R2 write frame at fastest divider, with R8 ignored writes during it
        rd_ofs = 3'd5;
        bus_write(3'd3, 32'hDEAD_A5C3);
        repeat (20) @(negedge clk);
        bus_write(3'd3, 32'h0000_1111);
        bus_write(3'd1, 32'h1);
        wait_idle();
        read_reg(3'd3, v); chk("R8 control kept", v, 32'h0000_A5C3);
        read_reg(3'd1, v); chk("R8 command kept", v, 32'h0);
        // R3 R5 read frame
        phy_word = 16'h1234;
        rd_ofs = 3'd5;
        bus_write(3'd1, 32'h1);
        read_reg(3'd5, v); chk("R5 not-valid set", v, 32'h5);
        wait_idle();
        read_reg(3'd4, v); chk("R5 read data", v, 32'h1234);
        bus_write(3'd1, 32'h1);
        read_reg(3'd5, v); chk("R3 no restart on level", v, 32'h0);
        // divider 1 read, divider 2 write
        bus_write(3'd0, 32'h1);
        bus_write(3'd2, 32'h0000_1C05);
        phy_word = 16'hBEEF;
        bus_write(3'd1, 32'h0);
        rd_ofs = 3'd4;
        bus_write(3'd1, 32'h1);
        wait_idle();
        read_reg(3'd4, v); chk("R5 second read", v, 32'hBEEF);
        bus_write(3'd0, 32'h2);
        rd_ofs = 3'd0;
        bus_write(3'd3, 32'h0000_0F0F);
        wait_idle();
        // R9 soft reset mid-frame
        bus_write(3'd3, 32'h0000_3C3C);
        repeat (40) @(negedge clk);
        bus_write(3'd0, 32'h8000_0001);
        rd_ofs = 3'd0;
        #2 chk("R9 reset bit visible", rd_data, 32'h8000_0001);
        read_reg(3'd0, v); chk("R9 reset bit clears", v, 32'h1);
        read_reg(3'd5, v); chk("R9 frame aborted", v, 32'h0);
        bus_write(3'd3, 32'h0000_7777);
        wait_idle();
        repeat (5) @(negedge clk);
        summary();
    end

endmodule